// File: doc/BRIEF.md
# Command and Interrupt Register Unit

This block is the host-side register file of a network controller. A host reaches it through a 6-bit register address, 16-bit write and read data, and single-cycle write and read strobes. A command register carries the control bits for the controller's functional units: receiver on and off, transmit and halt-transmit, timer start and stop, a software reset, a receive-resource fetch and an address-table load. Each accepted command bit produces a one-cycle strobe toward its unit. Done pulses from the units clear the matching command bits.

An interrupt status register gathers event pulses. The host clears its bits by writing ones to them. A mask register selects which status bits drive the single interrupt line. The block also holds configuration, transmit control, receive control, end-of-buffer count and tally registers, and each of these has its own write rule. Two configuration registers can be written only while the software reset bit is set.

Register map (address: register): 0 command, 1 interrupt status, 2 interrupt mask, 3 configuration, 4 second configuration, 5 transmit control, 6 receive control, 7 end-of-buffer count, 8 to 10 tally counters 0 to 2. All other addresses read as zero.

Top module: `nic_cmd_regs`

## Requirements
- R1: After rst_n is sampled low, the registers hold these values: command 0x0094 (reset, timer-stop and receiver-disable bits set), end-of-buffer count 0x02F8, mask 0, status 0, every other register 0. irq_o is low.
- R2: While command bit 7 (reset) is set, a command write with bit 7 clear only clears bit 7. No other command bit changes and no strobe fires.
- R3: Command bit 3 (receiver-enable) clears bit 2 (receiver-disable), and bit 2 clears bit 3. Bit 5 (timer-start) clears bit 4 (timer-stop), and bit 4 clears bit 5. When both bits of a pair are written together, the disable bit or the stop bit is kept and the other is dropped.
- R4: A command write with bit 7 set clears bits 9, 8, 1, 0 and 3. It sets bits 7 and 2. It fires sw_rst_stb and suppresses the transmit, resource-fetch and table-load strobes.
- R5: Only command bits in mask 0x03BF are stored. Bit 0 is halt-transmit, bit 1 transmit, bit 8 read-resource and bit 9 load-table. Each accepted bit pulses its strobe for exactly one cycle, in the cycle after the write.
- R6: tx_done clears command bit 1 and sets status bit 9. res_done clears command bit 8. tbl_done clears command bit 9 and sets status bit 12.
- R7: Writing to status clears each bit written as one. evt_set bits set status bits. When a set and a clear hit the same bit in the same cycle, the set wins.
- R8: irq_o is high exactly when (mask AND status) is nonzero. Mask bit 15 always reads 0, so it can never be enabled.
- R9: The configuration register takes writes only while command bit 7 is set, and stores them masked with 0xBFFF. The second configuration register follows the same rule with mask 0xF017. Writes at any other time leave both unchanged.
- R10: Transmit control stores only bits 15:12 of a write. Receive control stores only bits 15:5.
- R11: Each of the three tally registers stores the bitwise inverse of the value written. The end-of-buffer count stores the value written unchanged.
- R12: host_rdata presents the addressed register one cycle after host_rd. Unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 6 | Register address |
| host_wr | input | 1 | Write strobe, one cycle |
| host_rd | input | 1 | Read strobe, one cycle |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data, valid the cycle after host_rd |
| evt_set | input | 16 | Status bits to set this cycle |
| tx_done | input | 1 | Transmit unit finished |
| res_done | input | 1 | Resource fetch finished |
| tbl_done | input | 1 | Address-table load finished |
| irq_o | output | 1 | Interrupt request |
| halt_tx_stb | output | 1 | Halt-transmit strobe |
| tx_go_stb | output | 1 | Transmit strobe |
| rx_on_stb | output | 1 | Receiver-enable strobe |
| rx_off_stb | output | 1 | Receiver-disable strobe |
| tmr_stop_stb | output | 1 | Timer-stop strobe |
| tmr_start_stb | output | 1 | Timer-start strobe |
| sw_rst_stb | output | 1 | Software-reset strobe |
| res_fetch_stb | output | 1 | Resource-fetch strobe |
| tbl_load_stb | output | 1 | Address-table-load strobe |

## Verification
A wrong command state shows up in two places. The host sees it on the next read-back of the command register, one cycle after the read strobe. A functional unit sees it as a missing or extra strobe in the cycle right after the write. A stale reset bit is exposed at once: configuration writes are then either accepted or refused when they should not be. A wrong status or mask bit reaches irq_o in the same cycle the register updates, and status read-back shows it one cycle after the read.

// File: rtl/nic_regs_pkg.sv
// Package: shared register addresses, command bit positions and write masks
// for the command and interrupt register unit.
// Assumes a 16-bit register width and a 6-bit register address.
package nic_regs_pkg;

    localparam int DW = 16;
    localparam int AW = 6;

    // Register addresses
    localparam logic [AW-1:0] A_CMD    = 6'd0;
    localparam logic [AW-1:0] A_STAT   = 6'd1;
    localparam logic [AW-1:0] A_MASK   = 6'd2;
    localparam logic [AW-1:0] A_CFG    = 6'd3;
    localparam logic [AW-1:0] A_CFG2   = 6'd4;
    localparam logic [AW-1:0] A_TXC    = 6'd5;
    localparam logic [AW-1:0] A_RXC    = 6'd6;
    localparam logic [AW-1:0] A_EOB    = 6'd7;
    localparam logic [AW-1:0] A_TALLY0 = 6'd8;

    // Command bit positions
    localparam int B_HALT   = 0;
    localparam int B_TX     = 1;
    localparam int B_RXOFF  = 2;
    localparam int B_RXON   = 3;
    localparam int B_TSTOP  = 4;
    localparam int B_TSTART = 5;
    localparam int B_RST    = 7;
    localparam int B_RES    = 8;
    localparam int B_TBL    = 9;

    // Status bit positions set by unit done pulses
    localparam int S_TXDONE  = 9;
    localparam int S_TBLDONE = 12;

    // Write masks and reset values
    localparam logic [DW-1:0] CMD_KEEP  = 16'h03BF;
    localparam logic [DW-1:0] CMD_INIT  = 16'h0094;
    localparam logic [DW-1:0] MASK_KEEP = 16'h7FFF;
    localparam logic [DW-1:0] CFG_KEEP  = 16'hBFFF;
    localparam logic [DW-1:0] CFG2_KEEP = 16'hF017;
    localparam logic [DW-1:0] TXC_KEEP  = 16'hF000;
    localparam logic [DW-1:0] RXC_KEEP  = 16'hFFE0;
    localparam logic [DW-1:0] EOB_INIT  = 16'h02F8;

    // Strobe bundle, one bit per functional-unit command
    typedef struct packed {
        logic tbl_load;
        logic res_fetch;
        logic sw_rst;
        logic tmr_start;
        logic tmr_stop;
        logic rx_off;
        logic rx_on;
        logic tx_go;
        logic halt_tx;
    } strobe_t;

endpackage

// File: rtl/nic_cmd_ctrl.sv
// Module: command register and strobe generator.
// Decodes host command writes, applies the exclusive-pair and software-reset
// rules, leaves reset on a write without the reset bit, and clears the
// transmit, resource and table bits on the units' done pulses.
// Assumes: done pulses are single-cycle; a write in the same cycle as a done
// pulse re-sets the bit (write wins).
module nic_cmd_ctrl
    import nic_regs_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_wr,
    input  logic [DW-1:0] wdata,
    input  logic          tx_done,
    input  logic          res_done,
    input  logic          tbl_done,
    output logic [DW-1:0] cmd_q,
    output strobe_t       stb_q
);

    logic [DW-1:0] base;
    logic [DW-1:0] cmd_d;
    strobe_t       stb_d;
    logic          leaving_reset;

    // Purpose: detect a write that only takes the block out of reset.
    assign leaving_reset = cmd_wr && cmd_q[B_RST] && !wdata[B_RST];

    // Purpose: next command value and the strobes it implies.
    always_comb begin
        base = cmd_q;
        if (tx_done)  base[B_TX]  = 1'b0;
        if (res_done) base[B_RES] = 1'b0;
        if (tbl_done) base[B_TBL] = 1'b0;
        cmd_d = base;
        stb_d = '0;
        if (leaving_reset) begin
            cmd_d[B_RST] = 1'b0;
        end else if (cmd_wr) begin
            cmd_d = base | (wdata & CMD_KEEP);
            if (wdata[B_RXON] && !wdata[B_RXOFF]) cmd_d[B_RXOFF] = 1'b0;
            if (wdata[B_RXOFF])                   cmd_d[B_RXON]  = 1'b0;
            if (wdata[B_TSTART] && !wdata[B_TSTOP]) cmd_d[B_TSTOP]  = 1'b0;
            if (wdata[B_TSTOP])                     cmd_d[B_TSTART] = 1'b0;
            if (wdata[B_RST]) begin
                cmd_d[B_TBL]   = 1'b0;
                cmd_d[B_RES]   = 1'b0;
                cmd_d[B_TX]    = 1'b0;
                cmd_d[B_HALT]  = 1'b0;
                cmd_d[B_RXON]  = 1'b0;
                cmd_d[B_RST]   = 1'b1;
                cmd_d[B_RXOFF] = 1'b1;
            end
            stb_d.halt_tx   = wdata[B_HALT];
            stb_d.tx_go     = wdata[B_TX]  && !wdata[B_RST];
            stb_d.rx_on     = wdata[B_RXON] && !wdata[B_RXOFF];
            stb_d.rx_off    = wdata[B_RXOFF];
            stb_d.tmr_start = wdata[B_TSTART] && !wdata[B_TSTOP];
            stb_d.tmr_stop  = wdata[B_TSTOP];
            stb_d.sw_rst    = wdata[B_RST];
            stb_d.res_fetch = wdata[B_RES] && !wdata[B_RST];
            stb_d.tbl_load  = wdata[B_TBL] && !wdata[B_RST];
        end
    end

    // Purpose: command register and registered one-cycle strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= CMD_INIT;
            stb_q <= '0;
        end else begin
            cmd_q <= cmd_d;
            stb_q <= stb_d;
        end
    end

    // R3: receiver pair never both set
    p_rx_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_q[B_RXON] && cmd_q[B_RXOFF]));
    // R3: timer pair never both set
    p_tmr_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_q[B_TSTART] && cmd_q[B_TSTOP]));
    // R2: leaving reset touches only the reset bit
    p_leave_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (leaving_reset && !tx_done && !res_done && !tbl_done) |=>
        (cmd_q == ($past(cmd_q) & ~(16'h1 << B_RST))));
    // R2: leaving reset fires no strobe
    p_no_stb_r2: assert property (@(posedge clk) disable iff (!rst_n)
        leaving_reset |=> (stb_q == '0));
    // R4: software reset sets reset and receiver-disable
    p_swrst_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && wdata[B_RST]) |=> (cmd_q[B_RST] && cmd_q[B_RXOFF] && !cmd_q[B_TX]));
    // R5: strobes last one cycle when no write follows
    p_stb_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((stb_q != '0) && !cmd_wr) |=> (stb_q == '0));

endmodule

// File: rtl/nic_irq_ctrl.sv
// Module: interrupt status and mask registers, interrupt line.
// Status is write-one-to-clear with event set taking priority; the mask
// ignores bit 15. The interrupt line is the OR of masked status.
// Assumes event inputs are already single-cycle pulses.
module nic_irq_ctrl
    import nic_regs_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stat_wr,
    input  logic          mask_wr,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] evt,
    output logic [DW-1:0] stat_q,
    output logic [DW-1:0] mask_q,
    output logic          irq_o
);

    logic [DW-1:0] clr;

    // Purpose: bits the host asks to clear this cycle.
    assign clr = stat_wr ? wdata : '0;

    // Purpose: status and mask registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
            mask_q <= '0;
        end else begin
            stat_q <= (stat_q & ~clr) | evt;
            if (mask_wr) mask_q <= wdata & MASK_KEEP;
        end
    end

    // Purpose: level interrupt from masked status.
    assign irq_o = |(stat_q & mask_q);

    // R7: written ones are gone next cycle when no event arrives
    p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && evt == '0) |=> ((stat_q & $past(wdata)) == '0));
    // R7: events always land, even against a clear
    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((stat_q & $past(evt)) == $past(evt)));
    // R7: status holds without write or event
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_wr && evt == '0) |=> $stable(stat_q));
    // R8: interrupt requires a pending status bit
    p_irq_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (stat_q != '0));

endmodule

// File: rtl/nic_cfg_regs.sv
// Module: configuration, control, end-of-buffer and tally registers.
// Applies the per-register write rules: reset-only writes for the two
// configuration registers, field masks for the control registers, and
// inverted storage for the tally registers.
// Assumes in_reset reflects the current command reset bit.
module nic_cfg_regs
    import nic_regs_pkg::*;
#(
    parameter int NUM_TALLY = 3
)(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr,
    input  logic [AW-1:0]           addr,
    input  logic [DW-1:0]           wdata,
    input  logic                    in_reset,
    output logic [DW-1:0]           cfg_q,
    output logic [DW-1:0]           cfg2_q,
    output logic [DW-1:0]           txc_q,
    output logic [DW-1:0]           rxc_q,
    output logic [DW-1:0]           eob_q,
    output logic [NUM_TALLY*DW-1:0] tally_q
);

    // Purpose: plain and masked configuration and control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            cfg2_q <= '0;
            txc_q  <= '0;
            rxc_q  <= '0;
            eob_q  <= EOB_INIT;
        end else if (wr) begin
            if (addr == A_CFG  && in_reset) cfg_q  <= wdata & CFG_KEEP;
            if (addr == A_CFG2 && in_reset) cfg2_q <= wdata & CFG2_KEEP;
            if (addr == A_TXC)              txc_q  <= wdata & TXC_KEEP;
            if (addr == A_RXC)              rxc_q  <= wdata & RXC_KEEP;
            if (addr == A_EOB)              eob_q  <= wdata;
        end
    end

    // Purpose: one inverting tally register per counter.
    for (genvar g = 0; g < NUM_TALLY; g++) begin : g_tally
        localparam logic [AW-1:0] MY_ADDR = A_TALLY0 + AW'(g);
        always_ff @(posedge clk) begin
            if (!rst_n)
                tally_q[g*DW +: DW] <= '0;
            else if (wr && addr == MY_ADDR)
                tally_q[g*DW +: DW] <= ~wdata;
        end
    end

    // R9: configuration locked outside reset
    p_cfg_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == A_CFG && !in_reset) |=> $stable(cfg_q));
    // R9: second configuration locked outside reset
    p_cfg2_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == A_CFG2 && !in_reset) |=> $stable(cfg2_q));
    // R10: transmit control low bits stay clear
    p_txc_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == A_TXC) |=> (txc_q[11:0] == 12'h000));

endmodule

// File: rtl/nic_cmd_regs.sv
// Module: top of the command and interrupt register unit.
// Decodes the host write address, folds unit done pulses into status events,
// and returns registered read data.
// Assumes single-cycle host strobes and no simultaneous read and write hazard
// (a read returns the value before a same-cycle write).
module nic_cmd_regs
    import nic_regs_pkg::*;
#(
    parameter int NUM_TALLY = 3
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [5:0]    host_addr,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic [15:0]   host_wdata,
    output logic [15:0]   host_rdata,
    input  logic [15:0]   evt_set,
    input  logic          tx_done,
    input  logic          res_done,
    input  logic          tbl_done,
    output logic          irq_o,
    output logic          halt_tx_stb,
    output logic          tx_go_stb,
    output logic          rx_on_stb,
    output logic          rx_off_stb,
    output logic          tmr_stop_stb,
    output logic          tmr_start_stb,
    output logic          sw_rst_stb,
    output logic          res_fetch_stb,
    output logic          tbl_load_stb
);

    localparam logic [AW-1:0] A_LAST_TALLY = A_TALLY0 + AW'(NUM_TALLY - 1);

    logic [DW-1:0]           cmd_q, stat_q, mask_q;
    logic [DW-1:0]           cfg_q, cfg2_q, txc_q, rxc_q, eob_q;
    logic [NUM_TALLY*DW-1:0] tally_q;
    logic [DW-1:0]           evt_all;
    logic [DW-1:0]           rd_mux;
    strobe_t                 stb;

    // Purpose: merge external events with unit completion events.
    always_comb begin
        evt_all = evt_set;
        if (tx_done)  evt_all[S_TXDONE]  = 1'b1;
        if (tbl_done) evt_all[S_TBLDONE] = 1'b1;
    end

    nic_cmd_ctrl u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_wr   (host_wr && host_addr == A_CMD),
        .wdata    (host_wdata),
        .tx_done  (tx_done),
        .res_done (res_done),
        .tbl_done (tbl_done),
        .cmd_q    (cmd_q),
        .stb_q    (stb)
    );

    nic_irq_ctrl u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .stat_wr (host_wr && host_addr == A_STAT),
        .mask_wr (host_wr && host_addr == A_MASK),
        .wdata   (host_wdata),
        .evt     (evt_all),
        .stat_q  (stat_q),
        .mask_q  (mask_q),
        .irq_o   (irq_o)
    );

    nic_cfg_regs #(.NUM_TALLY(NUM_TALLY)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (host_wr),
        .addr     (host_addr),
        .wdata    (host_wdata),
        .in_reset (cmd_q[B_RST]),
        .cfg_q    (cfg_q),
        .cfg2_q   (cfg2_q),
        .txc_q    (txc_q),
        .rxc_q    (rxc_q),
        .eob_q    (eob_q),
        .tally_q  (tally_q)
    );

    assign halt_tx_stb   = stb.halt_tx;
    assign tx_go_stb     = stb.tx_go;
    assign rx_on_stb     = stb.rx_on;
    assign rx_off_stb    = stb.rx_off;
    assign tmr_stop_stb  = stb.tmr_stop;
    assign tmr_start_stb = stb.tmr_start;
    assign sw_rst_stb    = stb.sw_rst;
    assign res_fetch_stb = stb.res_fetch;
    assign tbl_load_stb  = stb.tbl_load;

    // Purpose: select the addressed register for read-back.
    always_comb begin
        rd_mux = '0;
        case (host_addr)
            A_CMD:  rd_mux = cmd_q;
            A_STAT: rd_mux = stat_q;
            A_MASK: rd_mux = mask_q;
            A_CFG:  rd_mux = cfg_q;
            A_CFG2: rd_mux = cfg2_q;
            A_TXC:  rd_mux = txc_q;
            A_RXC:  rd_mux = rxc_q;
            A_EOB:  rd_mux = eob_q;
            default: begin
                if (host_addr >= A_TALLY0 && host_addr <= A_LAST_TALLY)
                    rd_mux = tally_q[(host_addr - A_TALLY0)*DW +: DW];
            end
        endcase
    end

    // Purpose: registered read data, updated on each read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       host_rdata <= '0;
        else if (host_rd) host_rdata <= rd_mux;
    end

    // R8: mask bit 15 never reachable from the host
    p_mask_b15_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == A_MASK) |=> !mask_q[15]);
    // R6: transmit done drops the transmit command bit
    p_txdone_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done && !(host_wr && host_addr == A_CMD)) |=> (!cmd_q[B_TX] && stat_q[S_TXDONE]));

endmodule

// File: tb/tb_nic_cmd_regs.sv
// Directed bench for the command and interrupt register unit.
module tb_nic_cmd_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  host_addr = '0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic [15:0] evt_set = '0;
    logic        tx_done = 1'b0, res_done = 1'b0, tbl_done = 1'b0;
    logic        irq_o;
    logic        halt_tx_stb, tx_go_stb, rx_on_stb, rx_off_stb;
    logic        tmr_stop_stb, tmr_start_stb, sw_rst_stb, res_fetch_stb, tbl_load_stb;

    int n_vec = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    nic_cmd_regs dut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .evt_set(evt_set), .tx_done(tx_done), .res_done(res_done), .tbl_done(tbl_done),
        .irq_o(irq_o), .halt_tx_stb(halt_tx_stb), .tx_go_stb(tx_go_stb),
        .rx_on_stb(rx_on_stb), .rx_off_stb(rx_off_stb), .tmr_stop_stb(tmr_stop_stb),
        .tmr_start_stb(tmr_start_stb), .sw_rst_stb(sw_rst_stb),
        .res_fetch_stb(res_fetch_stb), .tbl_load_stb(tbl_load_stb)
    );

    // Strobe bundle: {tbl,res,swrst,tstart,tstop,rxoff,rxon,tx,halt}
    localparam logic [8:0] S_HALT = 9'h001, S_TX = 9'h002, S_RXON = 9'h004,
                           S_RXOFF = 9'h008, S_TSTOP = 9'h010, S_TSTART = 9'h020,
                           S_SWRST = 9'h040, S_RES = 9'h080, S_TBL = 9'h100;

    function automatic logic [8:0] strobes();
        return {tbl_load_stb, res_fetch_stb, sw_rst_stb, tmr_start_stb, tmr_stop_stb,
                rx_off_stb, rx_on_stb, tx_go_stb, halt_tx_stb};
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [15:0] d);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        d = host_rdata;
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: tx_done = 1'b1;
            1: res_done = 1'b1;
            default: tbl_done = 1'b1;
        endcase
        @(negedge clk);
        tx_done = 1'b0; res_done = 1'b0; tbl_done = 1'b0;
    endtask

    task automatic t_reset_values();
        logic [15:0] v;
        rd(6'd0, v); chk("R1 cmd", v, 16'h0094);
        rd(6'd7, v); chk("R1 eob", v, 16'h02F8);
        rd(6'd2, v); chk("R1 mask", v, 16'h0000);
        rd(6'd1, v); chk("R1 stat", v, 16'h0000);
        chk("R1 irq", {15'd0, irq_o}, 16'h0000);
    endtask

    task automatic t_cfg_in_reset();
        logic [15:0] v;
        wr(6'd3, 16'hFFFF); rd(6'd3, v); chk("R9 cfg", v, 16'hBFFF);
        wr(6'd4, 16'hFFFF); rd(6'd4, v); chk("R9 cfg2", v, 16'hF017);
    endtask

    task automatic t_leave_reset();
        logic [15:0] v;
        wr(6'd0, 16'h0302);
        chk("R2 no strobe", {7'd0, strobes()}, 16'h0000);
        rd(6'd0, v); chk("R2 cmd", v, 16'h0014);
        wr(6'd3, 16'h1234); rd(6'd3, v); chk("R9 cfg locked", v, 16'hBFFF);
        wr(6'd4, 16'h0000); rd(6'd4, v); chk("R9 cfg2 locked", v, 16'hF017);
    endtask

    task automatic t_pairs();
        logic [15:0] v;
        wr(6'd0, 16'h0008); chk("R3 rxon stb", {7'd0, strobes()}, {7'd0, S_RXON});
        rd(6'd0, v); chk("R3 rxon", v, 16'h0018);
        wr(6'd0, 16'h0020); chk("R3 tstart stb", {7'd0, strobes()}, {7'd0, S_TSTART});
        rd(6'd0, v); chk("R3 tstart", v, 16'h0028);
        wr(6'd0, 16'h0014); rd(6'd0, v); chk("R3 both off", v, 16'h0014);
        wr(6'd0, 16'h000C); chk("R3 rx clash stb", {7'd0, strobes()}, {7'd0, S_RXOFF});
        rd(6'd0, v); chk("R3 rx clash", v, 16'h0014);
        wr(6'd0, 16'h0030); chk("R3 tmr clash stb", {7'd0, strobes()}, {7'd0, S_TSTOP});
        rd(6'd0, v); chk("R3 tmr clash", v, 16'h0014);
    endtask

    task automatic t_units();
        logic [15:0] v;
        wr(6'd0, 16'h0002); chk("R5 tx stb", {7'd0, strobes()}, {7'd0, S_TX});
        @(negedge clk); chk("R5 stb one cycle", {7'd0, strobes()}, 16'h0000);
        rd(6'd0, v); chk("R5 tx bit", v, 16'h0016);
        pulse(0); rd(6'd0, v); chk("R6 tx_done cmd", v, 16'h0014);
        rd(6'd1, v); chk("R6 tx_done stat", v, 16'h0200);
        wr(6'd0, 16'h0100); chk("R5 res stb", {7'd0, strobes()}, {7'd0, S_RES});
        rd(6'd0, v); chk("R5 res bit", v, 16'h0114);
        pulse(1); rd(6'd0, v); chk("R6 res_done", v, 16'h0014);
        wr(6'd0, 16'h0200); chk("R5 tbl stb", {7'd0, strobes()}, {7'd0, S_TBL});
        pulse(2); rd(6'd0, v); chk("R6 tbl_done cmd", v, 16'h0014);
        rd(6'd1, v); chk("R6 tbl_done stat", v, 16'h1200);
        wr(6'd0, 16'hFC41); rd(6'd0, v); chk("R5 keep mask", v, 16'h0015);
    endtask

    task automatic t_irq();
        logic [15:0] v;
        wr(6'd2, 16'hFFFF); rd(6'd2, v); chk("R8 mask b15", v, 16'h7FFF);
        chk("R8 irq on", {15'd0, irq_o}, 16'h0001);
        wr(6'd1, 16'h0200); rd(6'd1, v); chk("R7 w1c", v, 16'h1000);
        wr(6'd2, 16'h0200); chk("R8 irq masked", {15'd0, irq_o}, 16'h0000);
        @(negedge clk); evt_set = 16'h8000; @(negedge clk); evt_set = '0;
        rd(6'd1, v); chk("R7 evt set", v, 16'h9000);
        wr(6'd2, 16'hFFFF); chk("R8 b15 never fires", {15'd0, irq_o}, 16'h0001);
        wr(6'd1, 16'hFFFF); rd(6'd1, v); chk("R7 clear all", v, 16'h0000);
        chk("R8 irq off", {15'd0, irq_o}, 16'h0000);
        @(negedge clk); evt_set = 16'h0004;
        wr(6'd1, 16'h0000);
        @(negedge clk); host_addr = 6'd1; host_wdata = 16'h0004; host_wr = 1'b1;
        @(negedge clk); host_wr = 1'b0; evt_set = '0;
        rd(6'd1, v); chk("R7 set wins", v, 16'h0004);
        wr(6'd2, 16'h0004); chk("R8 irq bit2", {15'd0, irq_o}, 16'h0001);
    endtask

    task automatic t_swrst();
        logic [15:0] v;
        wr(6'd0, 16'h0383);
        chk("R4 strobes", {7'd0, strobes()}, {7'd0, S_SWRST | S_HALT});
        rd(6'd0, v); chk("R4 cmd", v, 16'h0094);
        wr(6'd3, 16'h0F0F); rd(6'd3, v); chk("R9 cfg reopened", v, 16'h0F0F);
    endtask

    task automatic t_misc();
        logic [15:0] v;
        wr(6'd5, 16'hFFFF); rd(6'd5, v); chk("R10 txc", v, 16'hF000);
        wr(6'd6, 16'hFFFF); rd(6'd6, v); chk("R10 rxc", v, 16'hFFE0);
        wr(6'd8, 16'h1234); rd(6'd8, v); chk("R11 tally0", v, 16'hEDCB);
        wr(6'd10, 16'h00FF); rd(6'd10, v); chk("R11 tally2", v, 16'hFF00);
        wr(6'd7, 16'h0123); rd(6'd7, v); chk("R11 eob", v, 16'h0123);
        wr(6'h3F, 16'hFFFF); rd(6'h3F, v); chk("R12 unmapped", v, 16'h0000);
        @(negedge clk); host_addr = 6'd7; host_rd = 1'b1;
        @(posedge clk); #1 chk("R12 read latency", host_rdata, 16'h0123);
        @(negedge clk); host_rd = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_values();
        t_cfg_in_reset();
        t_leave_reset();
        t_pairs();
        t_units();
        t_irq();
        t_swrst();
        t_misc();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #2_000_000;
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule